// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides what happens to each received CAN frame once its identifier is known. It either accepts or rejects the frame. An accepted frame is routed to receive queue 0, receive queue 1 or a dedicated buffer. The block also reports whether the frame was marked as high priority, which filter element made the decision, and whether the frame was accepted only because of the fallback for frames that match no element.

Filter elements are held in two small register files. The standard list holds 11-bit identifiers and the extended list holds 29-bit identifiers, and both are loaded through a write port. The extended-format bit of the incoming frame selects which list is searched. All enabled elements are compared in parallel, and a priority chain picks the lowest-index hit as the deciding element. The result is registered and appears one clock after the request. Two global settings apply on top of the lists:

- a remote-frame policy, which can reject every remote frame outright;
- a non-matching policy, which decides what happens to frames that no element claims.

Top module: `can_id_filter`

## Requirements
- R1: After reset, `out_valid` is 0, every result output is 0, and every filter element reads as all zeros. An all-zero element is disabled, so a frame sent before any element is written is handled by the non-matching policy.
- R2: A request presented with `in_valid` high produces `out_valid` high on the next clock, carrying that frame's result. With no request, `out_valid` is low on the next clock.
- R3: A standard element is a 32-bit word with these fields: second ID in bits 10:0, reserved bits 15:11, first ID in bits 26:16, action in bits 29:27, type in bits 31:30. The type values are:
  - 0: match when first ID <= ID[10:0] <= second ID;
  - 1: match when ID[10:0] equals either ID;
  - 2: match when (ID AND second) equals (first AND second);
  - 3: the element never matches.
- R4: An extended element is a 64-bit word with these fields: first ID in bits 28:0, action in bits 31:29, reserved bit 61, second ID in bits 60:32, type in bits 63:62. The type values are:
  - 0: range match on (ID AND global extended mask);
  - 1: dual match;
  - 2: classic mask match;
  - 3: range match on the raw ID with no mask applied.
- R5: The action code of a matching element sets the result:
  - 1: accept to target 0 (queue 0);
  - 2: accept to target 1 (queue 1);
  - 7: accept to target 2 (dedicated buffer);
  - 5: accept to target 0 with the priority flag set;
  - 6: accept to target 1 with the priority flag set;
  - 3: reject.
- R6: Elements are considered in ascending index order, and the first enabled element that matches decides the result. An element is enabled only when its action code is non-zero and its index is below the configured list length for its list.
- R7: A matching element with action 4 sets the priority flag and does not end the search. A later element, or the non-matching policy, still decides the outcome. The priority flag also survives a later reject.
- R8: When `cfg_rej_remote` is 1, every remote frame is rejected with the priority flag, `out_fidx` and `out_nomatch` all 0. When it is 0, remote frames are filtered like data frames.
- R9: A frame that no element decides is handled by `cfg_nomatch`:
  - 0: accept to target 0;
  - 1: accept to target 1;
  - 2 or 3: reject.
  `out_nomatch` is 1 exactly when such a frame is accepted.
- R10: `out_fidx` gives the index of the deciding element, both for accepts and for rejects. It is 0 when no element decided the frame.
- R11: The extended-format bit of the frame selects the list. Standard frames ignore the extended list and identifier bits 28:11. Extended frames ignore the standard list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Element write strobe |
| cfg_ext | input | 1 | Write targets the extended list (1) or the standard list (0) |
| cfg_idx | input | 7 | Element index to write; out-of-range indices are ignored |
| cfg_wdata | input | 64 | Element word; a standard element uses bits 31:0 |
| cfg_rej_remote | input | 1 | 1: reject all remote frames |
| cfg_nomatch | input | 2 | Policy for frames no element decides |
| cfg_xmask | input | 29 | Global mask for type-0 extended range elements |
| cfg_std_len | input | $clog2(N_STD+1) | Number of active standard elements |
| cfg_ext_len | input | $clog2(N_EXT+1) | Number of active extended elements |
| in_valid | input | 1 | Frame identifier request |
| in_id | input | 29 | Frame identifier; standard frames use bits 10:0 |
| in_xtd | input | 1 | Extended-format frame |
| in_rtr | input | 1 | Remote frame |
| out_valid | output | 1 | Result valid, one clock after the request |
| out_accept | output | 1 | Frame accepted |
| out_target | output | 2 | 0 queue 0, 1 queue 1, 2 dedicated buffer |
| out_prio | output | 1 | Priority marking |
| out_fidx | output | 7 | Index of the deciding element |
| out_nomatch | output | 1 | Accepted by the non-matching policy |

## Verification
A corrupted filter element or a faulty comparator does not stay hidden. It changes the accept, target or index outputs for a contiguous band of identifiers, and that error shows up on the very next clock after a request in the band. Sweeping every standard identifier, and dense bands around each extended range edge and dual value, exposes such a fault on the first affected identifier. A broken priority chain or a broken fallback shows up as a wrong `out_fidx` or `out_nomatch` on identifiers claimed by two elements, or by none.

// File: rtl/can_id_filter.sv
module can_id_filter #(
  parameter int N_STD = 8,
  parameter int N_EXT = 4,
  localparam int SLW = $clog2(N_STD + 1),
  localparam int ELW = $clog2(N_EXT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_ext,
  input  logic [6:0]       cfg_idx,
  input  logic [63:0]      cfg_wdata,
  input  logic             cfg_rej_remote,
  input  logic [1:0]       cfg_nomatch,
  input  logic [28:0]      cfg_xmask,
  input  logic [SLW-1:0]   cfg_std_len,
  input  logic [ELW-1:0]   cfg_ext_len,
  input  logic             in_valid,
  input  logic [28:0]      in_id,
  input  logic             in_xtd,
  input  logic             in_rtr,
  output logic             out_valid,
  output logic             out_accept,
  output logic [1:0]       out_target,
  output logic             out_prio,
  output logic [6:0]       out_fidx,
  output logic             out_nomatch
);
  localparam int NMAX = (N_STD > N_EXT) ? N_STD : N_EXT;

  logic [31:0] std_mem [N_STD];
  logic [63:0] ext_mem [N_EXT];
  logic [N_STD-1:0] s_hit;
  logic [N_EXT-1:0] e_hit;
  logic [NMAX-1:0]  c_hit;
  logic [2:0]       c_act [NMAX];
  logic [10:0]      sid;
  logic [28:0]      xid_m;

  assign sid   = in_id[10:0];
  assign xid_m = in_id & cfg_xmask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_STD; i++) std_mem[i] <= '0;
      for (int i = 0; i < N_EXT; i++) ext_mem[i] <= '0;
    end else if (cfg_we) begin
      for (int i = 0; i < N_STD; i++)
        if (!cfg_ext && cfg_idx == 7'(i)) std_mem[i] <= cfg_wdata[31:0];
      for (int i = 0; i < N_EXT; i++)
        if (cfg_ext && cfg_idx == 7'(i)) ext_mem[i] <= cfg_wdata;
    end
  end

  for (genvar i = 0; i < N_STD; i++) begin : g_std
    logic [10:0] f1, f2;
    logic [1:0]  ft;
    logic        en;
    assign f2 = std_mem[i][10:0];
    assign f1 = std_mem[i][26:16];
    assign ft = std_mem[i][31:30];
    assign en = (std_mem[i][29:27] != 3'd0) && (SLW'(i) < cfg_std_len);
    assign s_hit[i] = en &&
      ((ft == 2'd0 && sid >= f1 && sid <= f2) ||
       (ft == 2'd1 && (sid == f1 || sid == f2)) ||
       (ft == 2'd2 && (sid & f2) == (f1 & f2)));
  end

  for (genvar i = 0; i < N_EXT; i++) begin : g_ext
    logic [28:0] f1, f2;
    logic [1:0]  ft;
    logic        en;
    assign f1 = ext_mem[i][28:0];
    assign f2 = ext_mem[i][60:32];
    assign ft = ext_mem[i][63:62];
    assign en = (ext_mem[i][31:29] != 3'd0) && (ELW'(i) < cfg_ext_len);
    assign e_hit[i] = en &&
      ((ft == 2'd0 && xid_m >= f1 && xid_m <= f2) ||
       (ft == 2'd1 && (in_id == f1 || in_id == f2)) ||
       (ft == 2'd2 && (in_id & f2) == (f1 & f2)) ||
       (ft == 2'd3 && in_id >= f1 && in_id <= f2));
  end

  for (genvar i = 0; i < NMAX; i++) begin : g_sel
    if (i < N_STD && i < N_EXT) begin : g_both
      assign c_hit[i] = in_xtd ? e_hit[i] : s_hit[i];
      assign c_act[i] = in_xtd ? ext_mem[i][31:29] : std_mem[i][29:27];
    end else if (i < N_STD) begin : g_sonly
      assign c_hit[i] = !in_xtd && s_hit[i];
      assign c_act[i] = std_mem[i][29:27];
    end else begin : g_eonly
      assign c_hit[i] = in_xtd && e_hit[i];
      assign c_act[i] = ext_mem[i][31:29];
    end
  end

  logic       r_acc, r_pri, r_nm, done;
  logic [1:0] r_tgt;
  logic [6:0] r_idx;

  always_comb begin
    done = 1'b0; r_acc = 1'b0; r_pri = 1'b0; r_nm = 1'b0;
    r_tgt = 2'd0; r_idx = 7'd0;
    for (int i = 0; i < NMAX; i++) begin
      if (!done && c_hit[i]) begin
        case (c_act[i])
          3'd4: r_pri = 1'b1;
          3'd3: begin done = 1'b1; r_idx = 7'(i); end
          default: begin
            done  = 1'b1;
            r_acc = 1'b1;
            r_idx = 7'(i);
            if (c_act[i] == 3'd5 || c_act[i] == 3'd6) r_pri = 1'b1;
            if (c_act[i] == 3'd2 || c_act[i] == 3'd6) r_tgt = 2'd1;
            else if (c_act[i] == 3'd7)                r_tgt = 2'd2;
          end
        endcase
      end
    end
    if (!done && !cfg_nomatch[1]) begin
      r_acc = 1'b1;
      r_nm  = 1'b1;
      r_tgt = {1'b0, cfg_nomatch[0]};
    end
    if (in_rtr && cfg_rej_remote) begin
      r_acc = 1'b0; r_pri = 1'b0; r_nm = 1'b0; r_tgt = 2'd0; r_idx = 7'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_accept <= 1'b0; out_target <= 2'd0;
      out_prio <= 1'b0; out_fidx <= 7'd0; out_nomatch <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_accept  <= r_acc;
        out_target  <= r_tgt;
        out_prio    <= r_pri;
        out_fidx    <= r_idx;
        out_nomatch <= r_nm;
      end
    end
  end

  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_REMOTE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_rtr && cfg_rej_remote) |=> (!out_accept && !out_prio && !out_nomatch)); // R8
  AST_NM_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
    out_nomatch |-> (out_accept && out_fidx == 7'd0 && out_target != 2'd2)); // R9
  AST_TARGET_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_target != 2'd3); // R5
  AST_REJECT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_accept) |-> out_target == 2'd0); // R5
endmodule

// File: tb/can_id_filter_tb.sv
module can_id_filter_tb;
  localparam int NS = 8;
  localparam int NE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_ext = 1'b0;
  logic [6:0] cfg_idx = '0;
  logic [63:0] cfg_wdata = '0;
  logic g_rrej = 1'b0;
  logic [1:0] g_nm = 2'd0;
  logic [28:0] g_xmask = '1;
  logic [3:0] g_slen = 4'd8;
  logic [2:0] g_elen = 3'd4;
  logic in_valid = 1'b0, in_xtd = 1'b0, in_rtr = 1'b0;
  logic [28:0] in_id = '0;
  logic out_valid, out_accept, out_prio, out_nomatch;
  logic [1:0] out_target;
  logic [6:0] out_fidx;

  logic [31:0] bstd [NS];
  logic [63:0] bext [NE];
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  can_id_filter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ext(cfg_ext), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rej_remote(g_rrej), .cfg_nomatch(g_nm),
    .cfg_xmask(g_xmask), .cfg_std_len(g_slen), .cfg_ext_len(g_elen),
    .in_valid(in_valid), .in_id(in_id), .in_xtd(in_xtd), .in_rtr(in_rtr),
    .out_valid(out_valid), .out_accept(out_accept), .out_target(out_target),
    .out_prio(out_prio), .out_fidx(out_fidx), .out_nomatch(out_nomatch));

  function automatic logic [31:0] sel(input int t, input int a, input int f1, input int f2);
    return {2'(t), 3'(a), 11'(f1), 5'b0, 11'(f2)};
  endfunction

  function automatic logic [63:0] xel(input int t, input int a, input logic [28:0] f1, input logic [28:0] f2);
    return {2'(t), 1'b0, f2, 3'(a), f1};
  endfunction

  // expected {accept, target, prio, fidx, nomatch}
  function automatic logic [11:0] model(input logic [28:0] id, input logic xtd, input logic rtr);
    logic acc = 0, pri = 0, nm = 0, done = 0, hit;
    logic [1:0] tg = 0;
    logic [6:0] fx = 0;
    int n, t, c;
    logic [28:0] a, b, v, m;
    if (rtr && g_rrej) return 12'd0;                   // R8
    n = xtd ? int'(g_elen) : int'(g_slen);             // R6, R11
    for (int i = 0; i < n; i++) begin
      if (xtd) begin
        a = bext[i][28:0]; b = bext[i][60:32]; c = bext[i][31:29]; t = bext[i][63:62];
        v = id; m = id & g_xmask;
        case (t)
          0: hit = (m >= a) && (m <= b);
          1: hit = (v == a) || (v == b);
          2: hit = ((v ^ a) & b) == 0;
          default: hit = (v >= a) && (v <= b);
        endcase
      end else begin
        a = 29'(bstd[i][26:16]); b = 29'(bstd[i][10:0]); c = bstd[i][29:27]; t = bstd[i][31:30];
        v = 29'(id[10:0]);
        case (t)
          0: hit = (v >= a) && (v <= b);
          1: hit = (v == a) || (v == b);
          2: hit = ((v ^ a) & b) == 0;
          default: hit = 0;
        endcase
      end
      if (!done && hit && c != 0) begin
        if (c == 4) pri = 1;
        else begin
          done = 1; fx = 7'(i);
          if (c != 3) begin
            acc = 1;
            tg = (c == 2 || c == 6) ? 2'd1 : (c == 7) ? 2'd2 : 2'd0;
            if (c == 5 || c == 6) pri = 1;
          end
        end
      end
    end
    if (!done && g_nm < 2) begin acc = 1; nm = 1; tg = 2'(g_nm); end
    return {acc, tg, pri, fx, nm};
  endfunction

  task automatic check(input string req, input logic [28:0] id, input logic [12:0] got, input logic [12:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s id=%h got=%h exp=%h", req, id, got, exp);
    end
  endtask

  task automatic send(input string req, input logic [28:0] id, input logic xtd, input logic rtr);
    in_valid = 1'b1; in_id = id; in_xtd = xtd; in_rtr = rtr;
    @(negedge clk);
    check(req, id, {out_valid, out_accept, out_target, out_prio, out_fidx, out_nomatch},
          {1'b1, model(id, xtd, rtr)});
    in_valid = 1'b0;
  endtask

  task automatic wr(input logic ext, input int idx, input logic [63:0] d);
    cfg_we = 1'b1; cfg_ext = ext; cfg_idx = 7'(idx); cfg_wdata = d;
    if (ext) bext[idx] = d; else bstd[idx] = d[31:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic std_sweep(input string req, input logic rtr);
    for (int i = 0; i < 2048; i++) send(req, {18'(i * 7 + 3), 11'(i)}, 1'b0, rtr);
  endtask

  task automatic ext_sweep(input string req);
    logic [28:0] bases [6] = '{29'h000FFF00, 29'h001FFF80, 29'h1ABCDE00,
                               29'h00000000, 29'h0A9FFF00, 29'h0AA00080};
    for (int k = 0; k < 6; k++)
      for (int i = 0; i < 512; i++) send(req, bases[k] + 29'(i), 1'b1, 1'b0);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    for (int i = 0; i < NS; i++) bstd[i] = '0;
    for (int i = 0; i < NE; i++) bext[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset outputs
    check("R1", '0, {out_valid, out_accept, out_target, out_prio, out_fidx, out_nomatch}, 13'd0);
    @(negedge clk);
    check("R2", '0, {12'd0, out_valid}, 13'd0);
    // R1: empty lists fall to non-matching policy
    send("R1", 29'h123, 1'b0, 1'b0);
    send("R1", 29'h1ABCDEF0, 1'b1, 1'b0);

    // standard list
    wr(0, 0, 64'(sel(0, 1, 'h100, 'h1FF)));
    wr(0, 1, 64'(sel(1, 2, 'h050, 'h250)));
    wr(0, 2, 64'(sel(2, 7, 'h300, 'h700)));
    wr(0, 3, 64'(sel(0, 3, 'h180, 'h2FF)));
    wr(0, 4, 64'(sel(0, 4, 'h400, 'h4FF)));
    wr(0, 5, 64'(sel(2, 6, 'h400, 'h780)));
    wr(0, 6, 64'(sel(3, 1, 'h000, 'h7FF)));
    wr(0, 7, 64'(sel(1, 5, 'h7FF, 'h000)));
    // extended list
    g_xmask = 29'h1FFFFF00;
    wr(1, 0, xel(0, 1, 29'h00100000, 29'h00100000));
    wr(1, 1, xel(3, 2, 29'h00200000, 29'h002000FF));
    wr(1, 2, xel(1, 7, 29'h1ABCDEF0, 29'h00000001));
    wr(1, 3, xel(2, 3, 29'h0AA00000, 29'h1FF00000));
    wr(1, 7, 64'hFFFF_FFFF_FFFF_FFFF); // R11: out-of-range index ignored
    bext[3] = xel(2, 3, 29'h0AA00000, 29'h1FF00000);

    // R3 R5 R6 R7 R9 R10 R11: all standard IDs under each non-matching policy
    for (int p = 0; p < 4; p++) begin
      g_nm = 2'(p);
      std_sweep("R3_R5_R6_R7_R9_R10_R11", 1'b0);
    end
    g_nm = 2'd0;
    g_slen = 4'd4;
    std_sweep("R6_len", 1'b0);                          // R6
    g_slen = 4'd8;
    wr(0, 0, 64'(sel(0, 0, 'h100, 'h1FF)));
    std_sweep("R6_disabled", 1'b0);                     // R6
    g_rrej = 1'b0;
    std_sweep("R8_filter_remote", 1'b1);                // R8
    g_rrej = 1'b1;
    for (int i = 0; i < 256; i++) send("R8_reject_remote", 29'(i * 9), i[0], 1'b1);
    g_rrej = 1'b0;

    // R4 R11: extended
    ext_sweep("R4_R11");
    g_nm = 2'd2;
    ext_sweep("R4_R9");
    g_nm = 2'd1;
    g_elen = 3'd2;
    ext_sweep("R4_R6_len");
    g_elen = 3'd4;
    wr(1, 0, xel(2, 4, 29'h0AA00000, 29'h1FF00000));
    wr(1, 1, xel(0, 6, 29'h0AA00000, 29'h0AA000FF));
    wr(1, 2, xel(1, 5, 29'h00000010, 29'h000FFF10));
    wr(1, 3, xel(3, 3, 29'h0AA00100, 29'h0AA0017F));
    g_xmask = 29'h1FFFFFF0;
    ext_sweep("R4_R7_R10");
    report();
  end
endmodule